// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block feeds outgoing frames from a ring of transmit buffer descriptors in memory. Software fills in descriptors, sets the ring base, turns the controller on and raises a transmit demand. The walker then reads descriptors one after another. For every descriptor marked ready it reads the data buffer it points to and sends those bytes on a byte stream with valid/ready handshake. It then writes the descriptor back with the ready mark removed and moves on to the next descriptor. The walk stops at the first descriptor that is not ready. The position it stopped at is kept for the next demand.

A frame may span several descriptors; the stream marks its final byte with `tx_tlast`. A per-descriptor wrap mark sends the walker back to the ring base, so the ring size is set by software. Frames longer than the `MAX_FRAME` parameter are cut to fit, and each cut raises a babbling-transmit event. All memory traffic uses one word port. Each request is held until it is acknowledged.

Descriptor layout: each descriptor is 8 bytes. The word at offset 0 holds the buffer length in bits [15:0], ready in bit 31, wrap in bit 29 and last-of-frame in bit 27. The word at offset 4 holds the byte address of the buffer, which may have any alignment.

Top module: `txbd_ring_engine`

## Requirements
- R1: After reset, `ring_base` and `cur_desc` are 0, and `busy`, `mem_req`, `tx_tvalid` and all three event outputs are low.
- R2: A base write stores `base_wdata` with bits [1:0] forced to 0 into `ring_base`. When no walk is running, the same value is also loaded into `cur_desc`.
- R3: A transmit demand while `ctl_enable` is low is ignored: no memory request is made and `cur_desc` keeps its value.
- R4: A walk ends when a descriptor's first word has bit 31 (ready) clear. `cur_desc` then keeps that descriptor's address.
- R5: For each ready descriptor, the buffer bytes go out in ascending address order, starting at any byte alignment. Within each memory word, byte lane k is bits [8k+7:8k]. `tx_tlast` is high only on the final byte of a buffer whose bit 27 (last) is set.
- R6: While `tx_tvalid` is high and `tx_tready` is low, `tx_tvalid`, `tx_tdata` and `tx_tlast` hold their values.
- R7: After a descriptor is sent, its first word is written back with bit 31 cleared and every other bit unchanged.
- R8: After the write-back, the next descriptor address is `ring_base` if bit 29 (wrap) was set, and the current address plus 8 otherwise.
- R9: `ev_txbuf` pulses once for each descriptor sent. `ev_txframe` pulses in the same cycle when that descriptor had last set. The frame length count then returns to zero.
- R10: If the bytes already sent in the frame plus a buffer's length would exceed `MAX_FRAME`, only the remaining room is sent and `ev_babble` pulses once.
- R11: A demand that arrives during a walk causes exactly one more walk, starting from `cur_desc`, after the current walk ends.
- R12: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller on; a demand is only taken while high |
| tx_demand | input | 1 | One-cycle transmit demand pulse |
| base_we | input | 1 | Ring base write strobe |
| base_wdata | input | ADDR_W | Ring base write value |
| ring_base | output | ADDR_W | Ring base, word aligned |
| cur_desc | output | ADDR_W | Address of the next descriptor to read |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word, low two bits zero |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tready | input | 1 | Stream sink ready |
| tx_tdata | output | 8 | Stream byte |
| tx_tlast | output | 1 | Final byte of a frame |
| ev_txbuf | output | 1 | Pulse: one descriptor sent |
| ev_txframe | output | 1 | Pulse: one frame completed |
| ev_babble | output | 1 | Pulse: a buffer was cut to the frame limit |

## Verification
A wrong descriptor pointer shows on `mem_addr` at the next header read and on `cur_desc` once the walk ends. Both are visible within a few cycles of the write-back. A lost wrap or a skipped ready test sends bytes from the wrong buffer, and the byte scoreboard flags this on the first byte that differs. A stale frame length count is not visible until the next frame that crosses the limit: the babble pulse then appears or goes missing, and the `tx_tlast` position moves. The pending-demand flag shows only as an extra header read of the stopping descriptor, which the memory model counts.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_PTR, ST_FETCH, ST_SEND, ST_WBACK
  } walk_st_e;

  localparam int DATA_W     = 32;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 16;
  // bit positions inside the first descriptor word
  localparam int BIT_READY  = 31;
  localparam int BIT_WRAP   = 29;
  localparam int BIT_LAST   = 27;
endpackage

// File: rtl/txbd_demand_ctl.sv
module txbd_demand_ctl (
  input  logic clk,
  input  logic rst,
  input  logic demand,
  input  logic enable,
  input  logic walk_idle,
  output logic start
);
  logic pending_q;

  assign start = walk_idle && enable && (demand || pending_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
    end else if (!enable || start) begin
      pending_q <= 1'b0;
    end else if (demand && !walk_idle) begin
      pending_q <= 1'b1;
    end
  end

  // R11: a recorded demand is served as soon as the walk is idle
  a_r11_pending_served: assert property (@(posedge clk) disable iff (rst)
    pending_q && walk_idle && enable |-> start);
endmodule

// File: rtl/txbd_len_clamp.sv
module txbd_len_clamp #(
  parameter int MAX_FRAME = 2048,
  parameter int LEN_W     = 16,
  parameter int ACC_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic [LEN_W-1:0] buf_len,
  input  logic [ACC_W-1:0] acc,
  output logic [LEN_W-1:0] eff_len,
  output logic             over
);
  logic [31:0] room;

  always_comb begin
    room    = 32'(MAX_FRAME) - 32'(acc);
    over    = 32'(buf_len) > room;
    eff_len = over ? room[LEN_W-1:0] : buf_len;
  end
endmodule

// File: rtl/txbd_byte_pick.sv
module txbd_byte_pick #(
  parameter int WORD_BYTES = 4,
  parameter int LANE_W     = $clog2(WORD_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [8*WORD_BYTES-1:0] word,
  input  logic [LANE_W-1:0]       lane,
  input  logic                    send,
  input  logic                    last_byte,
  input  logic                    tready,
  output logic                    tvalid,
  output logic [7:0]              tdata,
  output logic                    tlast
);
  logic [7:0] lanes [WORD_BYTES];

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign tvalid = send;
  assign tdata  = lanes[lane];
  assign tlast  = send && last_byte;

  // R6: a stalled byte does not change
  a_r6_stall_stable: assert property (@(posedge clk) disable iff (rst)
    tvalid && !tready |=> tvalid && $stable(tdata) && $stable(tlast));
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine
  import txbd_pkg::*;
#(
  parameter int MAX_FRAME = 2048,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_enable,
  input  logic              tx_demand,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic [ADDR_W-1:0] cur_desc,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_tvalid,
  input  logic              tx_tready,
  output logic [7:0]        tx_tdata,
  output logic              tx_tlast,
  output logic              ev_txbuf,
  output logic              ev_txframe,
  output logic              ev_babble
);
  localparam int ACC_W  = $clog2(MAX_FRAME + 1);
  localparam int LANE_W = $clog2(WORD_BYTES);

  walk_st_e          state_q;
  logic [ADDR_W-1:0] base_q, cur_q, bptr_q;
  logic [31:0]       hdr_q, word_q;
  logic [LEN_W-1:0]  remain_q, eff_len;
  logic [ACC_W-1:0]  acc_q;
  logic              over, start, send_fire;
  logic              ev_buf_q, ev_frame_q, ev_bab_q;

  txbd_demand_ctl u_demand (
    .clk       (clk),
    .rst       (rst),
    .demand    (tx_demand),
    .enable    (ctl_enable),
    .walk_idle (state_q == ST_IDLE),
    .start     (start)
  );

  txbd_len_clamp #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_clamp (
    .buf_len (hdr_q[LEN_W-1:0]),
    .acc     (acc_q),
    .eff_len (eff_len),
    .over    (over)
  );

  txbd_byte_pick #(.WORD_BYTES(WORD_BYTES)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .word      (word_q),
    .lane      (bptr_q[LANE_W-1:0]),
    .send      (state_q == ST_SEND),
    .last_byte ((remain_q == LEN_W'(1)) && hdr_q[BIT_LAST]),
    .tready    (tx_tready),
    .tvalid    (tx_tvalid),
    .tdata     (tx_tdata),
    .tlast     (tx_tlast)
  );

  assign send_fire = tx_tvalid && tx_tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      cur_q      <= '0;
      bptr_q     <= '0;
      hdr_q      <= '0;
      word_q     <= '0;
      remain_q   <= '0;
      acc_q      <= '0;
      ev_buf_q   <= 1'b0;
      ev_frame_q <= 1'b0;
      ev_bab_q   <= 1'b0;
    end else begin
      ev_buf_q   <= 1'b0;
      ev_frame_q <= 1'b0;
      ev_bab_q   <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) state_q <= ST_HDR;
        ST_HDR: if (mem_ack) begin
          if (!mem_rdata[BIT_READY]) begin
            state_q <= ST_IDLE;
          end else begin
            hdr_q   <= mem_rdata;
            state_q <= ST_PTR;
          end
        end
        ST_PTR: if (mem_ack) begin
          bptr_q   <= ADDR_W'(mem_rdata);
          remain_q <= eff_len;
          acc_q    <= acc_q + eff_len[ACC_W-1:0];
          ev_bab_q <= over;
          state_q  <= (eff_len == '0) ? ST_WBACK : ST_FETCH;
        end
        ST_FETCH: if (mem_ack) begin
          word_q  <= mem_rdata;
          state_q <= ST_SEND;
        end
        ST_SEND: if (send_fire) begin
          bptr_q   <= bptr_q + ADDR_W'(1);
          remain_q <= remain_q - LEN_W'(1);
          if (remain_q == LEN_W'(1)) begin
            state_q <= ST_WBACK;
          end else if (&bptr_q[LANE_W-1:0]) begin
            state_q <= ST_FETCH;
          end
        end
        ST_WBACK: if (mem_ack) begin
          ev_buf_q   <= 1'b1;
          ev_frame_q <= hdr_q[BIT_LAST];
          if (hdr_q[BIT_LAST]) acc_q <= '0;
          cur_q   <= hdr_q[BIT_WRAP] ? base_q : cur_q + ADDR_W'(DESC_BYTES);
          state_q <= ST_HDR;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (base_we) begin
        base_q <= {base_wdata[ADDR_W-1:2], 2'b00};
        if (state_q == ST_IDLE) cur_q <= {base_wdata[ADDR_W-1:2], 2'b00};
      end
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = hdr_q & ~(32'h1 << BIT_READY);
    case (state_q)
      ST_HDR:   begin mem_req = 1'b1; mem_addr = cur_q; end
      ST_PTR:   begin mem_req = 1'b1; mem_addr = cur_q + ADDR_W'(4); end
      ST_FETCH: begin mem_req = 1'b1; mem_addr = {bptr_q[ADDR_W-1:2], 2'b00}; end
      ST_WBACK: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_q; end
      default:  ;
    endcase
  end

  assign ring_base  = base_q;
  assign cur_desc   = cur_q;
  assign busy       = (state_q != ST_IDLE);
  assign ev_txbuf   = ev_buf_q;
  assign ev_txframe = ev_frame_q;
  assign ev_babble  = ev_bab_q;

  // R12: request held until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));
  // R7: every write-back carries a cleared ready bit
  a_r7_wb_not_ready: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[BIT_READY]);
  // R9: a frame completion always comes with a buffer completion
  a_r9_frame_with_buf: assert property (@(posedge clk) disable iff (rst)
    ev_txframe |-> ev_txbuf);
  // R10: frame byte count never passes the limit
  a_r10_acc_bound: assert property (@(posedge clk) disable iff (rst)
    32'(acc_q) <= 32'(MAX_FRAME));
  // R3: with the controller off an idle walker stays idle
  a_r3_off_stays_idle: assert property (@(posedge clk) disable iff (rst)
    !ctl_enable && !busy |=> !busy);
endmodule

// File: tb/test_txbd_ring_engine.sv
module test_txbd_ring_engine;
  localparam int MAXF = 24;
  localparam logic [15:0] FR = 16'h8000, FW = 16'h2000, FL = 16'h0800;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_enable = 1'b0, tx_demand = 1'b0, base_we = 1'b0, tx_tready = 1'b1;
  logic [31:0] base_wdata = '0;
  logic [31:0] ring_base, cur_desc, mem_addr, mem_wdata, rdata_q;
  logic busy, mem_req, mem_we, tx_tvalid, tx_tlast, ev_txbuf, ev_txframe, ev_babble;
  logic [7:0] tx_tdata;
  logic ack_q;
  logic [31:0] mem [0:255];
  int access_cnt = 0, rd118 = 0;
  int n_buf = 0, n_frame = 0, n_bab = 0;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  logic [8:0] exp_q [$];

  always #5 clk = ~clk;

  txbd_ring_engine #(.MAX_FRAME(MAXF), .ADDR_W(32)) i_txbd_ring_engine (
    .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .tx_demand(tx_demand),
    .base_we(base_we), .base_wdata(base_wdata), .ring_base(ring_base),
    .cur_desc(cur_desc), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(ack_q),
    .mem_rdata(rdata_q), .tx_tvalid(tx_tvalid), .tx_tready(tx_tready),
    .tx_tdata(tx_tdata), .tx_tlast(tx_tlast), .ev_txbuf(ev_txbuf),
    .ev_txframe(ev_txframe), .ev_babble(ev_babble));

  // memory model: one-cycle acknowledge, read data valid with it
  always @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else if (mem_req && !ack_q) begin
      ack_q   <= 1'b1;
      rdata_q <= mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      access_cnt <= access_cnt + 1;
      if (!mem_we && mem_addr == 32'h118) rd118 <= rd118 + 1;
    end else ack_q <= 1'b0;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor (R5, R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (ev_txbuf) n_buf++;
      if (ev_txframe) n_frame++;
      if (ev_babble) n_bab++;
      if (tx_tvalid && tx_tready) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected byte", {23'd0, tx_tlast, tx_tdata}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({tx_tlast, tx_tdata} == e, "R5 stream byte", {23'd0, tx_tlast, tx_tdata}, {23'd0, e});
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] dbyte(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic push_buf(input int ptr, input int n, input bit last);
    for (int i = 0; i < n; i++) exp_q.push_back({last && (i == n - 1), dbyte(ptr + i)});
  endtask

  task automatic set_desc(input int a, input logic [15:0] fl, input logic [15:0] len, input logic [31:0] p);
    mem[a >> 2] = {fl, len};
    mem[(a >> 2) + 1] = p;
  endtask

  task automatic pulse_demand();
    @(negedge clk) tx_demand = 1'b1;
    @(negedge clk) tx_demand = 1'b0;
  endtask

  task automatic wait_idle(input bit bp);
    int quiet = 0;
    for (int i = 0; i < 4000 && quiet < 4; i++) begin
      @(negedge clk);
      if (bp) tx_tready = ~tx_tready;
      quiet = busy ? 0 : quiet + 1;
    end
    tx_tready = 1'b1;
    check(!busy, "R4 walk ended", {31'd0, busy}, 0);
    check(exp_q.size() == 0, "R5 all bytes seen", exp_q.size(), 0);
  endtask

  initial begin
    int b0, f0, x0, r0, a0;
    for (int i = 0; i < 256; i++)
      mem[i] = {dbyte(4*i+3), dbyte(4*i+2), dbyte(4*i+1), dbyte(4*i)};
    for (int i = 64; i < 72; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ring_base == 0 && cur_desc == 0, "R1 pointers", cur_desc, 0);
    check(!busy && !mem_req && !tx_tvalid, "R1 idle", {busy, mem_req, tx_tvalid}, 0);
    check(!ev_txbuf && !ev_txframe && !ev_babble, "R1 events", {ev_txbuf, ev_txframe, ev_babble}, 0);

    // R2 base write with low bits forced to zero
    @(negedge clk) begin base_we = 1'b1; base_wdata = 32'h103; end
    @(negedge clk) base_we = 1'b0;
    check(ring_base == 32'h100, "R2 base", ring_base, 32'h100);
    check(cur_desc == 32'h100, "R2 reload", cur_desc, 32'h100);

    // R3 demand while disabled
    set_desc(32'h100, FR, 5, 32'h201);
    a0 = access_cnt;
    pulse_demand();
    repeat (20) @(negedge clk);
    check(access_cnt == a0, "R3 no access", access_cnt, a0);
    check(cur_desc == 32'h100, "R3 pointer kept", cur_desc, 32'h100);

    // R5 R7 R8 R9: two-descriptor frame, unaligned start
    ctl_enable = 1'b1;
    set_desc(32'h108, FR | FL, 6, 32'h240);
    push_buf(32'h201, 5, 0);
    push_buf(32'h240, 6, 1);
    b0 = n_buf; f0 = n_frame;
    pulse_demand();
    wait_idle(0);
    check(n_buf - b0 == 2, "R9 buffer events", n_buf - b0, 2);
    check(n_frame - f0 == 1, "R9 frame events", n_frame - f0, 1);
    check(cur_desc == 32'h110, "R4 R8 stop pointer", cur_desc, 32'h110);
    check(mem[32'h100 >> 2] == {FR & ~FR, 16'd5}, "R7 write-back d0", mem[32'h100 >> 2], 32'd5);
    check(mem[32'h108 >> 2] == {FL, 16'd6}, "R7 write-back d1", mem[32'h108 >> 2], {FL, 16'd6});

    // R11 demand recorded during a walk
    set_desc(32'h110, FR | FL, 3, 32'h300);
    push_buf(32'h300, 3, 1);
    r0 = rd118;
    tx_tready = 1'b0;
    pulse_demand();
    for (int i = 0; i < 200 && !tx_tvalid; i++) @(negedge clk);
    pulse_demand();
    tx_tready = 1'b1;
    wait_idle(0);
    check(rd118 - r0 == 2, "R11 extra walk", rd118 - r0, 2);
    check(cur_desc == 32'h118, "R4 pointer after R11", cur_desc, 32'h118);

    // R8 wrap with R6 backpressure
    set_desc(32'h118, FR | FL | FW, 7, 32'h305);
    push_buf(32'h305, 7, 1);
    pulse_demand();
    wait_idle(1);
    check(cur_desc == 32'h100, "R8 wrap to base", cur_desc, 32'h100);

    // R10 clamp at the frame limit
    set_desc(32'h100, FR, 16, 32'h340);
    set_desc(32'h108, FR | FL, 16, 32'h380);
    push_buf(32'h340, 16, 0);
    push_buf(32'h380, 8, 1);
    x0 = n_bab;
    pulse_demand();
    wait_idle(0);
    check(n_bab - x0 == 1, "R10 babble event", n_bab - x0, 1);
    check(mem[32'h108 >> 2] == {FL, 16'd16}, "R7 length kept after clamp", mem[32'h108 >> 2], {FL, 16'd16});

    // R9 length count restarts after last: a fresh short frame is not clamped
    set_desc(32'h110, FR | FL, 5, 32'h3C1);
    push_buf(32'h3C1, 5, 1);
    x0 = n_bab;
    pulse_demand();
    wait_idle(0);
    check(n_bab == x0, "R9 R10 no babble after restart", n_bab, x0);
    check(cur_desc == 32'h118, "R4 final pointer", cur_desc, 32'h118);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule